// File: doc/BRIEF.md
# Paged Direct Address Generator

This block turns the short offset field of a direct-addressing instruction word into a full data memory operand address. Data memory holds 65,536 words, viewed as 512 pages of 128 words. A compiler-mode input picks how the offset is based:

- **Page mode:** a 9-bit page number supplies the upper address bits.
- **Stack mode:** the 16-bit stack pointer is added to the offset.

A register-access request overrides both modes and pins the access to page 0, where the memory-mapped registers live.

The page number, stack pointer and mode bit are plain inputs owned by the surrounding core. The owner of the mode bit clears it at reset, so page mode is the default. The generator samples a request on a rising clock edge and presents the address and a valid flag from registers one cycle later. An instruction whose indirect flag is set is not a direct access, and it produces no valid address.

Top module: `dir_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after its release with no request made, `addr_out` is 0x0000 and `addr_vld` is 0.
- R2: In page mode (`stack_mode`=0, `mmr_req`=0), a direct request gives `addr_out` = {`page_reg`[8:0], offset[6:0]}; for example, page 2 with offset 1 gives 0x0101.
- R3: In stack mode (`stack_mode`=1, `mmr_req`=0), a direct request gives `addr_out` = (`stack_ptr` + zero-extended offset) mod 65536.
- R4: With `mmr_req`=1, a direct request gives `addr_out` = {9'b0, offset}, a page 0 address in 0x0000..0x007F, whatever `page_reg`, `stack_ptr` and `stack_mode` hold.
- R5: A request whose instruction bit 7 (indirect flag) is 1 leaves `addr_vld` at 0 in the next cycle, and `addr_out` keeps its previous value.
- R6: A direct request sampled on a rising edge (`req_valid`=1, `instr`[7]=0) sets `addr_vld`=1 after that edge. A cycle with `req_valid`=0 gives `addr_vld`=0 after the next edge, and `addr_out` is unchanged.
- R7: The offset is taken from `instr`[6:0] only; `instr`[15:8] has no effect on `addr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address request this cycle |
| instr | input | 16 | Instruction word; [6:0] offset, [7] indirect flag |
| page_reg | input | 9 | Current data page number |
| stack_ptr | input | 16 | Current stack pointer |
| stack_mode | input | 1 | 0: page-based, 1: stack-based |
| mmr_req | input | 1 | Force the access into page 0 |
| addr_out | output | 16 | Registered operand address |
| addr_vld | output | 1 | `addr_out` holds a fresh direct address |

## Verification
The bench targets the carry out of the stack sum near the top of memory. A design that drops the wrap, or that sign-extends offsets of 0x40 and above, produces a wrong address there. It also sets maximum page and stack values with `mmr_req` high; a design that lets them leak in gives a non-zero upper part. Indirect-flagged and idle cycles are checked for a stale valid or a changed address. Instructions that differ only in bits 15:8 are compared, to catch a wrongly placed offset field.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    BASE_PAGE  = 2'd0,
    BASE_STACK = 2'd1,
    BASE_ZERO  = 2'd2
  } base_sel_e;
endpackage

// File: rtl/dag_page_join.sv
module dag_page_join #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 7,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  offset,
  input  logic              force_zero,
  output logic [ADDR_W-1:0] addr
);
  logic [PAGE_W-1:0] page_eff;
  always_comb begin
    page_eff = force_zero ? '0 : page;
    addr     = {page_eff, offset};
  end
endmodule

// File: rtl/dag_stack_add.sv
module dag_stack_add #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 7
) (
  input  logic [ADDR_W-1:0] sp,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] off_ext;
  always_comb begin
    off_ext = {{(ADDR_W-OFF_W){1'b0}}, offset};
    addr    = sp + off_ext;
  end
endmodule

// File: rtl/dag_out_reg.sv
module dag_out_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              vld_q
);
  logic [ADDR_W-1:0] addr_d;
  logic              vld_d;

  always_comb begin
    addr_d = addr_q;
    vld_d  = load;
    if (load) addr_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      vld_q  <= vld_d;
    end
  end
endmodule

// File: rtl/dir_addr_gen.sv
module dir_addr_gen
  import dag_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 7,
  parameter int INSTR_W = 16,
  parameter int IND_BIT = 7,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [PAGE_W-1:0]  page_reg,
  input  logic [ADDR_W-1:0]  stack_ptr,
  input  logic               stack_mode,
  input  logic               mmr_req,
  output logic [ADDR_W-1:0]  addr_out,
  output logic               addr_vld
);
  logic [OFF_W-1:0]  offset;
  logic              is_direct;
  logic              load;
  base_sel_e         base_sel;
  logic [ADDR_W-1:0] page_addr;
  logic [ADDR_W-1:0] stack_addr;
  logic [ADDR_W-1:0] sel_addr;

  always_comb begin
    offset    = instr[OFF_W-1:0];
    is_direct = ~instr[IND_BIT];
    load      = req_valid & is_direct;
    if (mmr_req)         base_sel = BASE_ZERO;
    else if (stack_mode) base_sel = BASE_STACK;
    else                 base_sel = BASE_PAGE;
  end

  dag_page_join #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_join (
    .page       (page_reg),
    .offset     (offset),
    .force_zero (base_sel == BASE_ZERO),
    .addr       (page_addr)
  );

  dag_stack_add #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_add (
    .sp     (stack_ptr),
    .offset (offset),
    .addr   (stack_addr)
  );

  always_comb begin
    sel_addr = (base_sel == BASE_STACK) ? stack_addr : page_addr;
  end

  dag_out_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .addr_in (sel_addr),
    .addr_q  (addr_out),
    .vld_q   (addr_vld)
  );

  assert_indirect_no_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && instr[IND_BIT]) |=> (!addr_vld && $stable(addr_out)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_vld && $stable(addr_out)));

  assert_direct_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !instr[IND_BIT]) |=> addr_vld);

  assert_mmr_page0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !instr[IND_BIT] && mmr_req) |=>
      (addr_out[ADDR_W-1:OFF_W] == '0 && addr_out[OFF_W-1:0] == $past(instr[OFF_W-1:0])));

  assert_page_join_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !instr[IND_BIT] && !mmr_req && !stack_mode) |=>
      (addr_out == {$past(page_reg), $past(instr[OFF_W-1:0])}));

  assert_stack_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !instr[IND_BIT] && !mmr_req && stack_mode) |=>
      (ADDR_W'(addr_out - $past(stack_ptr)) == ADDR_W'($past(instr[OFF_W-1:0]))));
endmodule

// File: tb/tb_dir_addr_gen.sv
module tb_dir_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] instr;
  logic [8:0]  page_reg;
  logic [15:0] stack_ptr;
  logic        stack_mode;
  logic        mmr_req;
  logic [15:0] addr_out;
  logic        addr_vld;

  int          n_checks = 0;
  int          n_errors = 0;
  logic [15:0] exp_addr;
  logic        exp_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
    .page_reg(page_reg), .stack_ptr(stack_ptr), .stack_mode(stack_mode),
    .mmr_req(mmr_req), .addr_out(addr_out), .addr_vld(addr_vld)
  );

  function automatic logic [15:0] model_addr(input logic [15:0] ins, input logic [8:0] pg,
                                             input logic [15:0] sp, input logic md,
                                             input logic mm);
    logic [15:0] off;
    off = {9'd0, ins[6:0]};
    if (mm)      return off;
    else if (md) return 16'(sp + off);
    else         return {pg, ins[6:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] a, input logic v,
                       input logic [15:0] ea, input logic ev);
    n_checks++;
    if (a !== ea || v !== ev) begin
      n_errors++;
      $display("FAIL %s: addr=%h vld=%b expected addr=%h vld=%b", req, a, v, ea, ev);
    end
  endtask

  task automatic step(input string req, input logic rv, input logic [15:0] ins,
                      input logic [8:0] pg, input logic [15:0] sp,
                      input logic md, input logic mm);
    req_valid = rv; instr = ins; page_reg = pg; stack_ptr = sp;
    stack_mode = md; mmr_req = mm;
    if (rv && !ins[7]) begin
      exp_addr = model_addr(ins, pg, sp, md, mm);
      exp_vld  = 1'b1;
    end else begin
      exp_vld  = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(req, addr_out, addr_vld, exp_addr, exp_vld);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 0; instr = 0; page_reg = 0; stack_ptr = 0;
    stack_mode = 0; mmr_req = 0;
    exp_addr = 16'h0000; exp_vld = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", addr_out, addr_vld, 16'h0000, 1'b0);
    rst_n = 1'b1;
    step("R1 after release", 1'b0, 16'h0000, 9'h0, 16'h0, 1'b0, 1'b0);

    // R2: page 2, offset 1 -> 0x0101
    step("R2 page example", 1'b1, 16'h0001, 9'd2, 16'hAAAA, 1'b0, 1'b0);
    check("R2 literal", addr_out, addr_vld, 16'h0101, 1'b1);
    step("R2 top page", 1'b1, 16'h007F, 9'h1FF, 16'h0, 1'b0, 1'b0);
    check("R2 literal top", addr_out, addr_vld, 16'hFFFF, 1'b1);
    // R3: wrap and offsets above 0x3F must be zero-extended
    step("R3 wrap", 1'b1, 16'h007F, 9'h0, 16'hFFF0, 1'b1, 1'b0);
    check("R3 literal wrap", addr_out, addr_vld, 16'h006F, 1'b1);
    step("R3 zero-extend", 1'b1, 16'h0040, 9'h0, 16'h1000, 1'b1, 1'b0);
    check("R3 literal ext", addr_out, addr_vld, 16'h1040, 1'b1);
    // R4: MMR override ignores page, sp, mode
    step("R4 mmr page mode", 1'b1, 16'h0060, 9'h1FF, 16'hFFFF, 1'b0, 1'b1);
    check("R4 literal", addr_out, addr_vld, 16'h0060, 1'b1);
    step("R4 mmr stack mode", 1'b1, 16'h007F, 9'h1FF, 16'hFF00, 1'b1, 1'b1);
    check("R4 literal 2", addr_out, addr_vld, 16'h007F, 1'b1);
    // R5: indirect flag blocks output, address held at 0x007F
    step("R5 indirect", 1'b1, 16'h0085, 9'h003, 16'h1234, 1'b0, 1'b0);
    check("R5 held", addr_out, addr_vld, 16'h007F, 1'b0);
    // R6: idle holds, then valid returns
    step("R6 idle", 1'b0, 16'h0011, 9'h005, 16'h0, 1'b0, 1'b0);
    step("R6 direct after idle", 1'b1, 16'h0011, 9'h005, 16'h0, 1'b0, 1'b0);
    // R7: upper instruction bits ignored
    step("R7 upper bits set", 1'b1, 16'hFF05, 9'h00A, 16'h0, 1'b0, 1'b0);
    check("R7 literal", addr_out, addr_vld, 16'h0505, 1'b1);
    step("R7 upper bits stack", 1'b1, 16'h7A33, 9'h0, 16'h0100, 1'b1, 1'b0);
    check("R7 literal stack", addr_out, addr_vld, 16'h0133, 1'b1);

    // Random mix covering R2..R7
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R2-R7 random", (r[3:0] != 4'd0), 16'($urandom) & ((r[5:4] == 2'd0) ? 16'hFFFF : 16'hFF7F),
           9'($urandom), 16'($urandom), r[6], (r[9:7] == 3'd0));
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule